// File: doc/BRIEF.md
# Critical Instruction Confidence Table

This block keeps one small saturating confidence counter per table slot and uses it to guess whether an instruction now being fetched is likely to sit on the performance-limiting dependence chain. The fetch stage presents a program counter and, one cycle later, receives a single "critical" guess that travels down the pipeline with the instruction. The guess is kept apart from the instruction's "marked" flag, which the execution stages set when the instruction meets some criticality heuristic.

Training happens only at retirement. When an instruction commits, its program counter selects a slot and its marked flag either raises the counter by a large step or lowers it by a small step, both saturating. Because the rise is much steeper than the fall, a guess stays asserted for a while after the instruction stops being marked. That matters when the optimisation driven by the guess itself removes the instruction from the critical chain. The step sizes and the decision level are live inputs, so software-free tuning, including a gentler 2-up/1-down setting, needs no rebuild. The table has no tags, so distinct instructions that share index bits share a counter. A walk-through clear sets every counter to zero, one slot per cycle, and the same walk runs after reset.

Top module: `crit_path_table`

## Requirements
- R1: The slot index is program counter bits [IDX_W+1:2]; bits 1:0 and all bits above the index are ignored, so addresses differing only there share one counter (no tag).
- R2: A commit with the marked flag set adds `inc_amt` to the slot's counter, saturating at 63 (6-bit counter).
- R3: A commit with the marked flag clear subtracts `dec_amt` from the counter, saturating at 0.
- R4: One cycle after a fetch with `fetch_valid` high, `pred_valid` is 1 and `pred_crit` is 1 only if the counter is strictly greater than `thresh`. Equality gives 0. With `fetch_valid` low, `pred_valid` is 0 in the next cycle.
- R5: The table changes only on cycles with `commit_valid` high; `commit_marked` and `commit_pc` have no effect otherwise.
- R6: When a fetch and a commit hit the same slot in one cycle, the prediction uses the counter value from before that commit.
- R7: `inc_amt`, `dec_amt` and `thresh` are sampled on every cycle, so a change takes effect on the next commit or fetch. This includes a 2-up/1-down setting.
- R8: A one-cycle `clear_req` while idle raises `clear_busy` for exactly 1024 cycles (one per slot) and then leaves every counter at 0. While busy, commits are dropped, `pred_crit` is 0 and `clear_req` is ignored.
- R9: While `rst_n` is low, `pred_valid` and `pred_crit` are 0 and `clear_busy` is 1. After release, the clear walk of R8 runs, so `clear_busy` falls after 1024 cycles with all counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch lookup request |
| fetch_pc | input | 32 | Program counter of fetched instruction |
| pred_valid | output | 1 | Prediction present (one cycle after request) |
| pred_crit | output | 1 | Instruction predicted critical |
| commit_valid | input | 1 | A retiring instruction trains the table |
| commit_pc | input | 32 | Program counter of retiring instruction |
| commit_marked | input | 1 | Retiring instruction met the criticality criterion |
| inc_amt | input | 6 | Step added on a marked commit |
| dec_amt | input | 6 | Step subtracted on an unmarked commit |
| thresh | input | 6 | Counter must exceed this to predict critical |
| clear_req | input | 1 | Start the table-wide clear walk |
| clear_busy | output | 1 | Clear walk in progress |

## Verification
A fetch result is due on the clock edge after the request. A commit updates its counter at its own edge, so a fetch in the next cycle sees the new value, while a fetch in the same cycle sees the old one. `clear_busy` rises on the edge that takes `clear_req` and falls 1024 edges later. The reference model advances on each rising edge with exactly these latencies and predicts the outputs of that edge. The outputs are compared on the following falling edge, and directed literal checks sample at the same point after the stimulus that produced them.

// File: rtl/cpt_pkg.sv
// Shared definitions for the critical instruction confidence table.
// Assumes word-aligned instruction addresses.
package cpt_pkg;
    localparam int ALIGN_LSB = 2;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/cpt_pc_index.sv
// Turns a program counter into a table slot index.
// Assumes PC_W > IDX_W + ALIGN_LSB; alignment bits and upper bits are dropped (no tag kept).
module cpt_pc_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    import cpt_pkg::*;
    localparam int HI = IDX_W + ALIGN_LSB;

    // select the index field above the alignment bits
    assign idx = pc[HI-1:ALIGN_LSB];

    logic unused_pc_bits;
    // fold the ignored bits so they are consumed
    assign unused_pc_bits = ^{pc[PC_W-1:HI], pc[ALIGN_LSB-1:0]};
endmodule

// File: rtl/cpt_sat_step.sv
// Computes the next value of one confidence counter.
// A marked commit adds inc (ceiling all-ones); an unmarked one subtracts dec (floor zero).
module cpt_sat_step #(
    parameter int CNT_W = 6
) (
    input  logic             en,
    input  logic [CNT_W-1:0] cur,
    input  logic             marked,
    input  logic [CNT_W-1:0] inc,
    input  logic [CNT_W-1:0] dec,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0] sum;

    // widened sum exposes the carry for the ceiling test
    assign sum = {1'b0, cur} + {1'b0, inc};

    // pick the saturated up or down step
    always_comb begin
        if (marked) begin
            nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end else begin
            nxt = (cur < dec) ? '0 : (cur - dec);
        end
    end

    // a marked step never lowers the counter, an unmarked one never raises it
    always_comb begin
        if (en && marked) begin
            assert_up_monotone_R2: assert (nxt >= cur);
        end
        if (en && !marked) begin
            assert_down_monotone_R3: assert (nxt <= cur);
        end
    end
endmodule

// File: rtl/cpt_clear_walk.sv
// Walks an index across every slot, one per cycle, to zero the table.
// Starts on reset and on a request while idle; requests while running are ignored.
module cpt_clear_walk #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    import cpt_pkg::*;
    localparam logic [IDX_W-1:0] LAST = '1;

    walk_state_e state_q;

    // advance the walk state and slot pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WALK_RUN;
            idx     <= '0;
        end else if (state_q == WALK_RUN) begin
            idx <= idx + 1'b1;
            if (idx == LAST) begin
                state_q <= WALK_IDLE;
            end
        end else if (start) begin
            state_q <= WALK_RUN;
            idx     <= '0;
        end
    end

    assign busy = (state_q == WALK_RUN);

    assert_clear_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_clear_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && idx == LAST) |=> !busy);
endmodule

// File: rtl/crit_path_table.sv
// Critical instruction confidence table: untagged, direct-mapped array of
// saturating counters read at fetch (registered result) and trained at commit.
// Assumes at most one fetch lookup and one commit per cycle.
module crit_path_table #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_valid,
    output logic             pred_crit,
    input  logic             commit_valid,
    input  logic [PC_W-1:0]  commit_pc,
    input  logic             commit_marked,
    input  logic [CNT_W-1:0] inc_amt,
    input  logic [CNT_W-1:0] dec_amt,
    input  logic [CNT_W-1:0] thresh,
    input  logic             clear_req,
    output logic             clear_busy
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CNT_W-1:0] table_q [DEPTH];
    logic [IDX_W-1:0] fetch_idx, commit_idx, walk_idx;
    logic [CNT_W-1:0] commit_cur, commit_nxt;
    logic             train_en;

    cpt_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fetch_idx (
        .pc(fetch_pc), .idx(fetch_idx)
    );

    cpt_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_commit_idx (
        .pc(commit_pc), .idx(commit_idx)
    );

    cpt_clear_walk #(.IDX_W(IDX_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(clear_req),
        .busy(clear_busy), .idx(walk_idx)
    );

    // commits train only when no clear walk owns the write port
    assign train_en   = commit_valid && !clear_busy;
    assign commit_cur = table_q[commit_idx];

    cpt_sat_step #(.CNT_W(CNT_W)) u_step (
        .en(train_en), .cur(commit_cur), .marked(commit_marked),
        .inc(inc_amt), .dec(dec_amt), .nxt(commit_nxt)
    );

    // single write port: the clear walk has priority over training
    always_ff @(posedge clk) begin
        if (clear_busy) begin
            table_q[walk_idx] <= '0;
        end else if (commit_valid) begin
            table_q[commit_idx] <= commit_nxt;
        end
    end

    // registered fetch lookup; reads the pre-write value on a same-slot collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid <= 1'b0;
            pred_crit  <= 1'b0;
        end else begin
            pred_valid <= fetch_valid;
            pred_crit  <= fetch_valid && !clear_busy && (table_q[fetch_idx] > thresh);
        end
    end

    assert_pred_follows_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> pred_valid);
    assert_no_pred_without_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!pred_valid && !pred_crit));
    assert_quiet_while_clearing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_busy |=> !pred_crit);
endmodule

// File: tb/sim_crit_path_table.sv
`timescale 1ns/1ps
module sim_crit_path_table;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_valid, pred_crit, clear_busy;
    logic        commit_valid = 1'b0;
    logic [31:0] commit_pc = '0;
    logic        commit_marked = 1'b0;
    logic [5:0]  inc_amt = 6'd8;
    logic [5:0]  dec_amt = 6'd1;
    logic [5:0]  thresh = 6'd8;
    logic        clear_req = 1'b0;

    int checks = 0;
    int errors = 0;
    string cur_req = "R9";
    bit chk_en = 1'b0;

    always #2.5 clk = ~clk;

    crit_path_table u0 (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_valid(pred_valid), .pred_crit(pred_crit),
        .commit_valid(commit_valid), .commit_pc(commit_pc), .commit_marked(commit_marked),
        .inc_amt(inc_amt), .dec_amt(dec_amt), .thresh(thresh),
        .clear_req(clear_req), .clear_busy(clear_busy)
    );

    // behavioural reference model, advanced on each rising edge
    int model [DEPTH];
    int left_cycles = 0;
    bit exp_busy = 1'b1, exp_pv = 1'b0, exp_pc = 1'b0;

    function automatic int slot(input logic [31:0] pc);
        return int'((pc / 4) % DEPTH);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (model[i]) model[i] = 0;
            exp_busy = 1'b1; left_cycles = DEPTH; exp_pv = 1'b0; exp_pc = 1'b0;
        end else begin
            exp_pv = fetch_valid;
            exp_pc = fetch_valid && !exp_busy && (model[slot(fetch_pc)] > int'(thresh));
            if (exp_busy) begin
                left_cycles = left_cycles - 1;
                if (left_cycles == 0) exp_busy = 1'b0;
            end else begin
                if (commit_valid) begin
                    int c;
                    c = model[slot(commit_pc)];
                    if (commit_marked) c = (c + int'(inc_amt) > 63) ? 63 : c + int'(inc_amt);
                    else               c = (c < int'(dec_amt)) ? 0 : c - int'(dec_amt);
                    model[slot(commit_pc)] = c;
                end
                if (clear_req) begin
                    foreach (model[i]) model[i] = 0;
                    exp_busy = 1'b1; left_cycles = DEPTH;
                end
            end
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            checks++;
            if (pred_valid !== exp_pv || pred_crit !== exp_pc || clear_busy !== exp_busy) begin
                errors++;
                $display("FAIL %s: pv/pc/busy actual %b%b%b expected %b%b%b at %0t",
                         cur_req, pred_valid, pred_crit, clear_busy, exp_pv, exp_pc, exp_busy, $time);
            end
        end
    end

    task automatic lit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle of inputs starting at a falling edge
    task automatic cyc(input bit fv, input logic [31:0] fpc,
                       input bit cv, input logic [31:0] cpc, input bit cm);
        fetch_valid = fv; fetch_pc = fpc;
        commit_valid = cv; commit_pc = cpc; commit_marked = cm;
        @(negedge clk);
        fetch_valid = 1'b0; commit_valid = 1'b0; commit_marked = 1'b0; clear_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (clear_busy) @(negedge clk);
    endtask

    localparam logic [31:0] PA = 32'h0000_1230;
    localparam logic [31:0] PB = 32'h0000_2000;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_en = 1'b1;
        cur_req = "R9";
        lit("R9", clear_busy, 1'b1);
        lit("R9", pred_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        wait_idle();
        lit("R9", clear_busy, 1'b0);

        // threshold boundary: 8 is not above 8, 16 is
        cur_req = "R4";
        cyc(0, 0, 1, PA, 1);
        cyc(1, PA, 0, 0, 0);
        lit("R4", pred_crit, 1'b0);
        cyc(0, 0, 1, PA, 1);
        cyc(1, PA, 0, 0, 0);
        lit("R4", pred_crit, 1'b1);
        lit("R4", pred_valid, 1'b1);

        // aliasing: upper bits and byte offset do not separate entries
        cur_req = "R1";
        cyc(1, PA + 32'd4096, 0, 0, 0);
        lit("R1", pred_crit, 1'b1);
        cyc(1, PA + 32'h0010_0003, 0, 0, 0);
        lit("R1", pred_crit, 1'b1);
        cyc(1, PA + 32'd4, 0, 0, 0);
        lit("R1", pred_crit, 1'b0);

        // decrement with floor; counter 16 -> 8 after eight unmarked commits
        cur_req = "R3";
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, PA, 0);
        cyc(1, PA, 0, 0, 0);
        lit("R3", pred_crit, 1'b0);
        for (int i = 0; i < 12; i++) cyc(0, 0, 1, PA, 0);
        cyc(0, 0, 1, PA, 1);
        cyc(1, PA, 0, 0, 0);
        lit("R3", pred_crit, 1'b0);

        // ceiling at 63: ten marked commits, then 7 down leaves 56 > 55
        cur_req = "R2";
        for (int i = 0; i < 10; i++) cyc(0, 0, 1, PB, 1);
        thresh = 6'd55;
        for (int i = 0; i < 7; i++) cyc(0, 0, 1, PB, 0);
        cyc(1, PB, 0, 0, 0);
        lit("R2", pred_crit, 1'b1);
        cyc(0, 0, 1, PB, 0);
        cyc(1, PB, 0, 0, 0);
        lit("R2", pred_crit, 1'b0);
        thresh = 6'd8;

        // marked flag without commit_valid leaves the counter alone
        cur_req = "R5";
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, PA + 32'd8, 1);
        cyc(1, PA + 32'd8, 0, 0, 0);
        lit("R5", pred_crit, 1'b0);

        // same-slot fetch and commit: old value returned
        cur_req = "R6";
        cyc(0, 0, 1, PA + 32'd12, 1);
        cyc(1, PA + 32'd12, 1, PA + 32'd12, 1);
        lit("R6", pred_crit, 1'b0);
        cyc(1, PA + 32'd12, 0, 0, 0);
        lit("R6", pred_crit, 1'b1);

        // gentler 2-up/1-down setting with a lower level
        cur_req = "R7";
        inc_amt = 6'd2; dec_amt = 6'd1; thresh = 6'd3;
        cyc(0, 0, 1, PA + 32'd16, 1);
        cyc(0, 0, 1, PA + 32'd16, 1);
        cyc(1, PA + 32'd16, 0, 0, 0);
        lit("R7", pred_crit, 1'b1);
        cyc(0, 0, 1, PA + 32'd16, 0);
        cyc(1, PA + 32'd16, 0, 0, 0);
        lit("R7", pred_crit, 1'b0);

        // mixed traffic compared by the model
        cur_req = "R7";
        for (int i = 0; i < 1500; i++) begin
            if (i % 300 == 0) begin
                inc_amt = 6'($urandom_range(1, 12));
                dec_amt = 6'($urandom_range(1, 3));
                thresh  = 6'($urandom_range(2, 20));
            end
            cyc($urandom_range(0, 1), 32'($urandom_range(0, 15) * 4),
                $urandom_range(0, 1), 32'($urandom_range(0, 15) * 4),
                $urandom_range(0, 1));
        end
        inc_amt = 6'd8; dec_amt = 6'd1; thresh = 6'd8;

        // clear walk: busy 1024 cycles, commits dropped, counters zero after
        cur_req = "R8";
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, PB, 1);
        clear_req = 1'b1;
        cyc(0, 0, 0, 0, 0);
        lit("R8", clear_busy, 1'b1);
        for (int i = 0; i < 4; i++) cyc(1, PB, 1, PB, 1);
        lit("R8", pred_crit, 1'b0);
        clear_req = 1'b1;
        cyc(0, 0, 0, 0, 0);
        repeat (1018) @(negedge clk);
        lit("R8", clear_busy, 1'b1);
        @(negedge clk);
        lit("R8", clear_busy, 1'b0);
        cyc(1, PB, 0, 0, 0);
        lit("R8", pred_crit, 1'b0);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule